// File: doc/BRIEF.md
# Scoreboard Issue Control Unit

This block is the dynamic scheduling controller for a small group of functional units. Each cycle it is offered one decoded instruction: a unit kind, an operation code, a destination register and two source registers. It decides whether that instruction may enter a functional unit now. After an instruction has entered a unit, the block also decides when the unit may read its operands and when it may write its result. The block keeps a status entry for every functional unit and a result table that records, for every architectural register, which unit will write it next. The execution datapath, the register file and any forwarding stay outside this block. They act on the per-unit grant pulses, and each unit pulses an execution-done input when its multi-cycle operation finishes.

Instructions enter in program order and can finish out of order. Three hazards are enforced. A write-after-write conflict, or a busy unit of the needed kind, holds the instruction at the entry point. A read-after-write dependency holds the operand read. A write-after-read conflict holds the write-back. A held instruction raises a stall output toward fetch, and every instruction behind it waits. There are four units: two integer units, one multiplier and one divider. They serve eight registers.

Top module: `scb_issue_ctrl`

## Requirements
- R1: After synchronous reset every unit is free, every register has no pending writer, and `stall`, `issue_grant`, `read_grant` and `wb_grant` are all zero while `instr_valid` is low.
- R2: `instr_kind` is encoded 0 = integer, 1 = multiply, 2 = divide (3 is never granted). Grant bits are ordered 0 and 1 for the integer units, 2 for the multiplier and 3 for the divider. An instruction is accepted in the same cycle it is presented when a unit of its kind is free and its destination has no pending writer. The accepted instruction gets a one-hot `issue_grant`, and an integer instruction takes the lowest-numbered free integer unit. From the next cycle, `unit_op` bits [u*4+3:u*4] hold the operation code of unit u.
- R3: While no unit of the requested kind is free, `stall` is high and `issue_grant` is zero. A unit becomes available again in the cycle after its `wb_grant`.
- R4: While any in-flight instruction will write the requested destination register, `stall` is high. Issue becomes possible in the cycle after that writer's `wb_grant`.
- R5: `read_grant[u]` is high for exactly one cycle. If neither source of the instruction has a pending writer at issue, that cycle is the one right after issue. Otherwise it is the cycle after the last producing unit's `wb_grant`.
- R6: An `exec_done[u]` pulse while unit u is executing makes the unit ready to write back. `wb_grant[u]` may then rise from the next cycle on. `exec_done` has no effect in any other phase.
- R7: `wb_grant[u]` is withheld while another in-flight instruction has a source equal to u's destination that is ready but not yet read. It is released in the cycle after that instruction's `read_grant`.
- R8: In the cycle after `wb_grant[u]`, unit u is free and u's destination register no longer has a pending writer.
- R9: If an instruction is issued in the same cycle as the write-back of the unit producing one of its sources, that source counts as ready, and the operand read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | A decoded instruction is presented |
| instr_kind | input | 2 | Unit kind needed (0 integer, 1 multiply, 2 divide) |
| instr_op | input | 4 | Operation code carried to the unit |
| instr_dst | input | 3 | Destination register |
| instr_src1 | input | 3 | First source register |
| instr_src2 | input | 3 | Second source register |
| exec_done | input | 4 | Per-unit end-of-execution pulse |
| stall | output | 1 | Presented instruction not accepted this cycle |
| issue_grant | output | 4 | One-hot unit receiving the presented instruction |
| read_grant | output | 4 | Per-unit permission to read operands |
| wb_grant | output | 4 | Per-unit permission to write the result |
| unit_op | output | 16 | Operation code held by each unit, 4 bits per unit |

## Verification
The hardest situation to reach is the write-after-read hold. It needs an older instruction that has one source ready and unread while its other source is still waiting, and a younger instruction that overwrites the ready source and finishes first. The bench builds this from a divide that feeds a multiply's second source, followed by an integer instruction that writes the multiply's first source. The divider's execution is then held long enough for the integer unit to finish first. A second awkward case is an issue that lands in exactly the cycle its producer writes back. The bench reaches it by timing the producer's done pulse so that its write-back cycle lines up with the consumer's presentation.

// File: rtl/scb_pkg.sv
package scb_pkg;
    localparam int NUM_INT  = 2;
    localparam int NUM_REGS = 8;
    localparam int OP_W     = 4;
    localparam int NUM_FU   = NUM_INT + 2;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int FU_W     = $clog2(NUM_FU);
    localparam int MUL_IDX  = NUM_INT;
    localparam int DIV_IDX  = NUM_INT + 1;

    typedef enum logic [1:0] {
        K_INT = 2'd0,
        K_MUL = 2'd1,
        K_DIV = 2'd2,
        K_RSV = 2'd3
    } unit_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_OPS = 2'd1,
        PH_EXEC     = 2'd2,
        PH_WB_READY = 2'd3
    } phase_e;

    // producer tag: pend set when a unit still has to deliver the value
    typedef struct packed {
        logic            pend;
        logic [FU_W-1:0] fu;
    } tag_t;

    typedef struct packed {
        phase_e           phase;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        tag_t             qj;
        tag_t             qk;
        logic             rj;
        logic             rk;
    } fu_entry_t;

    function automatic logic entry_busy(fu_entry_t e);
        return e.phase != PH_IDLE;
    endfunction

    // a producer writing back in this very cycle no longer counts as pending
    function automatic tag_t resolve_tag(tag_t t, logic [NUM_FU-1:0] wb);
        tag_t r;
        r = t;
        if (t.pend && wb[t.fu]) r = '0;
        return r;
    endfunction
endpackage

// File: rtl/scb_alloc.sv
module scb_alloc
    import scb_pkg::*;
(
    input  unit_kind_e        kind,
    input  logic [NUM_FU-1:0] busy_vec,
    output logic [NUM_FU-1:0] gnt,
    output logic              found
);
    always_comb begin
        gnt   = '0;
        found = 1'b0;
        unique case (kind)
            K_INT: begin
                for (int i = 0; i < NUM_INT; i++) begin
                    if (!found && !busy_vec[i]) begin
                        gnt[i] = 1'b1;
                        found  = 1'b1;
                    end
                end
            end
            K_MUL: begin
                if (!busy_vec[MUL_IDX]) begin
                    gnt[MUL_IDX] = 1'b1;
                    found        = 1'b1;
                end
            end
            K_DIV: begin
                if (!busy_vec[DIV_IDX]) begin
                    gnt[DIV_IDX] = 1'b1;
                    found        = 1'b1;
                end
            end
            default: begin
                gnt   = '0;
                found = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/scb_regstat.sv
module scb_regstat
    import scb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         set_en,
    input  logic [REG_W-1:0]             set_dst,
    input  logic [FU_W-1:0]              set_fu,
    input  logic [NUM_FU-1:0]            wb_vec,
    input  logic [NUM_FU-1:0][REG_W-1:0] fu_dst,
    output tag_t                         tbl [NUM_REGS]
);
    tag_t tbl_nxt [NUM_REGS];

    always_comb begin
        for (int r = 0; r < NUM_REGS; r++) begin
            tbl_nxt[r] = tbl[r];
            for (int u = 0; u < NUM_FU; u++) begin
                if (wb_vec[u] && fu_dst[u] == REG_W'(r)) tbl_nxt[r] = '0;
            end
            if (set_en && set_dst == REG_W'(r)) begin
                tbl_nxt[r].pend = 1'b1;
                tbl_nxt[r].fu   = set_fu;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rst) tbl[r] <= '0;
            else     tbl[r] <= tbl_nxt[r];
        end
    end
endmodule

// File: rtl/scb_fu_entry.sv
module scb_fu_entry
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [OP_W-1:0]   op,
    input  logic [REG_W-1:0]  dst,
    input  logic [REG_W-1:0]  src1,
    input  logic [REG_W-1:0]  src2,
    input  tag_t              qj_in,
    input  tag_t              qk_in,
    input  logic              done,
    input  logic [NUM_FU-1:0] wb_bus,
    input  logic              war_clear,
    output fu_entry_t         ent,
    output logic              rd_gnt,
    output logic              wb_gnt
);
    always_comb begin
        rd_gnt = (ent.phase == PH_WAIT_OPS) && ent.rj && ent.rk;
        wb_gnt = (ent.phase == PH_WB_READY) && war_clear;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else begin
            unique case (ent.phase)
                PH_IDLE: begin
                    if (alloc) begin
                        ent.phase <= PH_WAIT_OPS;
                        ent.op    <= op;
                        ent.fi    <= dst;
                        ent.fj    <= src1;
                        ent.fk    <= src2;
                        ent.qj    <= qj_in;
                        ent.qk    <= qk_in;
                        ent.rj    <= !qj_in.pend;
                        ent.rk    <= !qk_in.pend;
                    end
                end
                PH_WAIT_OPS: begin
                    if (rd_gnt) begin
                        // operands consumed: later WAR checks must see them as read
                        ent.phase <= PH_EXEC;
                        ent.rj    <= 1'b0;
                        ent.rk    <= 1'b0;
                    end else begin
                        if (ent.qj.pend && wb_bus[ent.qj.fu]) begin
                            ent.qj <= '0;
                            ent.rj <= 1'b1;
                        end
                        if (ent.qk.pend && wb_bus[ent.qk.fu]) begin
                            ent.qk <= '0;
                            ent.rk <= 1'b1;
                        end
                    end
                end
                PH_EXEC: begin
                    if (done) ent.phase <= PH_WB_READY;
                end
                PH_WB_READY: begin
                    if (wb_gnt) ent.phase <= PH_IDLE;
                end
                default: ent.phase <= PH_IDLE;
            endcase
        end
    end

    // R5: one read pulse, then the unit is executing
    p_read_once_r5: assert property (@(posedge clk) disable iff (rst)
        rd_gnt |=> (ent.phase == PH_EXEC) && !rd_gnt);

    // R5: a source that is not ready always names a producer
    p_unready_has_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (ent.phase == PH_WAIT_OPS && !ent.rj) |-> ent.qj.pend);

    // R8: write-back frees the unit
    p_wb_frees_r8: assert property (@(posedge clk) disable iff (rst)
        wb_gnt |=> (ent.phase == PH_IDLE));
endmodule

// File: rtl/scb_issue_ctrl.sv
module scb_issue_ctrl
    import scb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   instr_valid,
    input  logic [1:0]             instr_kind,
    input  logic [OP_W-1:0]        instr_op,
    input  logic [REG_W-1:0]       instr_dst,
    input  logic [REG_W-1:0]       instr_src1,
    input  logic [REG_W-1:0]       instr_src2,
    input  logic [NUM_FU-1:0]      exec_done,
    output logic                   stall,
    output logic [NUM_FU-1:0]      issue_grant,
    output logic [NUM_FU-1:0]      read_grant,
    output logic [NUM_FU-1:0]      wb_grant,
    output logic [NUM_FU*OP_W-1:0] unit_op
);
    fu_entry_t                    ents [NUM_FU];
    tag_t                         rstat [NUM_REGS];
    logic [NUM_FU-1:0]            busy_vec;
    logic [NUM_FU-1:0]            alloc_gnt;
    logic                         alloc_found;
    logic [NUM_FU-1:0]            war_clear;
    logic [NUM_FU-1:0][REG_W-1:0] fu_dst;
    logic [FU_W-1:0]              issue_idx;
    tag_t                         qj_new;
    tag_t                         qk_new;
    logic                         accept;

    scb_alloc u_alloc (
        .kind     (unit_kind_e'(instr_kind)),
        .busy_vec (busy_vec),
        .gnt      (alloc_gnt),
        .found    (alloc_found)
    );

    always_comb begin
        stall       = instr_valid && (!alloc_found || rstat[instr_dst].pend);
        accept      = instr_valid && !stall;
        issue_grant = accept ? alloc_gnt : '0;
        issue_idx   = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (alloc_gnt[u]) issue_idx = FU_W'(u);
        end
        qj_new = resolve_tag(rstat[instr_src1], wb_grant);
        qk_new = resolve_tag(rstat[instr_src2], wb_grant);
    end

    // WAR: hold a write while any other unit still has that register ready but unread
    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war_clear[u] = 1'b1;
            for (int f = 0; f < NUM_FU; f++) begin
                if (f != u && entry_busy(ents[f]) &&
                    ((ents[f].fj == ents[u].fi && ents[f].rj) ||
                     (ents[f].fk == ents[u].fi && ents[f].rk)))
                    war_clear[u] = 1'b0;
            end
        end
    end

    scb_regstat u_regstat (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept),
        .set_dst (instr_dst),
        .set_fu  (issue_idx),
        .wb_vec  (wb_grant),
        .fu_dst  (fu_dst),
        .tbl     (rstat)
    );

    for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
        scb_fu_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .alloc     (issue_grant[u]),
            .op        (instr_op),
            .dst       (instr_dst),
            .src1      (instr_src1),
            .src2      (instr_src2),
            .qj_in     (qj_new),
            .qk_in     (qk_new),
            .done      (exec_done[u]),
            .wb_bus    (wb_grant),
            .war_clear (war_clear[u]),
            .ent       (ents[u]),
            .rd_gnt    (read_grant[u]),
            .wb_gnt    (wb_grant[u])
        );

        always_comb begin
            busy_vec[u]                 = entry_busy(ents[u]);
            fu_dst[u]                   = ents[u].fi;
            unit_op[u*OP_W +: OP_W]     = ents[u].op;
        end

        // R3: a unit that is still in flight is never handed a new instruction
        p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (rst)
            busy_vec[u] |-> !issue_grant[u]);

        // R4: no two in-flight units ever target the same register
        for (genvar w = u + 1; w < NUM_FU; w++) begin : g_pair
            p_no_waw_r4: assert property (@(posedge clk) disable iff (rst)
                !(busy_vec[u] && busy_vec[w] && fu_dst[u] == fu_dst[w]));
        end
    end

    // R2: at most one unit receives the presented instruction
    p_issue_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_grant));

    // R4: an accepted destination is marked pending in the next cycle
    p_dst_marked_r4: assert property (@(posedge clk) disable iff (rst)
        accept |=> rstat[$past(instr_dst)].pend);
endmodule

// File: tb/sim_scb_issue_ctrl.sv
`timescale 1ns/1ps
module sim_scb_issue_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_valid;
    logic [1:0]  instr_kind;
    logic [3:0]  instr_op;
    logic [2:0]  instr_dst, instr_src1, instr_src2;
    logic [3:0]  exec_done;
    logic        stall;
    logic [3:0]  issue_grant, read_grant, wb_grant;
    logic [15:0] unit_op;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    scb_issue_ctrl u0 (
        .clk (clk), .rst (rst),
        .instr_valid (instr_valid), .instr_kind (instr_kind), .instr_op (instr_op),
        .instr_dst (instr_dst), .instr_src1 (instr_src1), .instr_src2 (instr_src2),
        .exec_done (exec_done), .stall (stall), .issue_grant (issue_grant),
        .read_grant (read_grant), .wb_grant (wb_grant), .unit_op (unit_op)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic present(input logic [1:0] k, input logic [3:0] op,
                           input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
        instr_valid = 1'b1;
        instr_kind  = k;
        instr_op    = op;
        instr_dst   = d;
        instr_src1  = s1;
        instr_src2  = s2;
    endtask

    task automatic drain();
        tick();
        instr_valid = 1'b0;
        exec_done   = 4'hF;
        repeat (12) tick();
        exec_done = 4'h0;
        #1 chk("R8 drained idle", {stall, read_grant, wb_grant}, 9'h0);
    endtask

    task automatic t_reset();
        rst = 1'b1; instr_valid = 1'b0; exec_done = 4'h0;
        present(2'd0, 4'd0, 3'd0, 3'd0, 3'd0);
        instr_valid = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1 stall", stall, 1'b0);
        chk("R1 grants", {issue_grant, read_grant, wb_grant}, 12'h0);
    endtask

    task automatic t_basic();
        tick(); present(2'd0, 4'd5, 3'd1, 3'd2, 3'd3);
        #1 chk("R2 int issue", issue_grant, 4'b0001);
        chk("R2 no stall", stall, 1'b0);
        tick(); instr_valid = 1'b0;
        #1 chk("R5 read next cycle", read_grant, 4'b0001);
        chk("R2 unit_op", unit_op[3:0], 4'd5);
        tick(); exec_done = 4'b0001;
        #1 chk("R5 read one cycle", read_grant, 4'b0000);
        chk("R6 no wb before done", wb_grant, 4'b0000);
        tick(); exec_done = 4'b0000;
        #1 chk("R6 wb after done", wb_grant, 4'b0001);
        tick(); present(2'd0, 4'd6, 3'd1, 3'd0, 3'd0);
        #1 chk("R8 wb once", wb_grant, 4'b0000);
        chk("R8 reissue same unit and dst", issue_grant, 4'b0001);
        drain();
    endtask

    task automatic t_struct();
        tick(); present(2'd0, 4'd1, 3'd1, 3'd0, 3'd0);
        #1 chk("R2 int lowest", issue_grant, 4'b0001);
        tick(); present(2'd0, 4'd2, 3'd2, 3'd0, 3'd0);
        #1 chk("R2 int second", issue_grant, 4'b0010);
        tick(); present(2'd1, 4'd3, 3'd3, 3'd0, 3'd0);
        #1 chk("R2 mul unit", issue_grant, 4'b0100);
        tick(); present(2'd2, 4'd4, 3'd4, 3'd0, 3'd0);
        #1 chk("R2 div unit", issue_grant, 4'b1000);
        tick(); present(2'd0, 4'd7, 3'd5, 3'd0, 3'd0); exec_done = 4'b0010;
        #1 chk("R3 stall no int", stall, 1'b1);
        chk("R3 no grant", issue_grant, 4'b0000);
        tick(); exec_done = 4'b0000;
        #1 chk("R3 stall during wb", stall, 1'b1);
        chk("R6 int1 wb", wb_grant, 4'b0010);
        tick();
        #1 chk("R3 issue after wb", issue_grant, 4'b0010);
        chk("R3 stall released", stall, 1'b0);
        drain();
    endtask

    task automatic t_waw();
        tick(); present(2'd1, 4'd2, 3'd4, 3'd0, 3'd0);
        #1 chk("R2 mul issue", issue_grant, 4'b0100);
        tick(); present(2'd0, 4'd3, 3'd4, 3'd0, 3'd0);
        #1 chk("R4 waw stall", stall, 1'b1);
        chk("R4 waw no grant", issue_grant, 4'b0000);
        tick(); exec_done = 4'b0100;
        #1 chk("R4 waw stall held", stall, 1'b1);
        tick(); exec_done = 4'b0000;
        #1 chk("R4 stall at wb cycle", stall, 1'b1);
        chk("R6 mul wb", wb_grant, 4'b0100);
        tick();
        #1 chk("R4 issue after wb", issue_grant, 4'b0001);
        drain();
    endtask

    task automatic t_raw();
        tick(); present(2'd2, 4'd1, 3'd5, 3'd0, 3'd0);
        #1 chk("R2 div issue", issue_grant, 4'b1000);
        tick(); present(2'd0, 4'd2, 3'd6, 3'd5, 3'd0);
        #1 chk("R2 dependent issue", issue_grant, 4'b0001);
        tick(); instr_valid = 1'b0;
        #1 chk("R5 raw hold a", read_grant, 4'b0000);
        tick(); exec_done = 4'b1000;
        #1 chk("R5 raw hold b", read_grant, 4'b0000);
        tick(); exec_done = 4'b0000;
        #1 chk("R5 raw hold at wb", read_grant, 4'b0000);
        chk("R6 div wb", wb_grant, 4'b1000);
        tick();
        #1 chk("R5 read after producer wb", read_grant, 4'b0001);
        drain();
    endtask

    task automatic t_war();
        tick(); present(2'd2, 4'd1, 3'd1, 3'd0, 3'd0);
        #1 chk("R2 div", issue_grant, 4'b1000);
        tick(); present(2'd1, 4'd2, 3'd7, 3'd2, 3'd1);
        #1 chk("R2 mul", issue_grant, 4'b0100);
        tick(); present(2'd0, 4'd3, 3'd2, 3'd3, 3'd3);
        #1 chk("R2 int", issue_grant, 4'b0001);
        chk("R5 mul waits", read_grant, 4'b0000);
        tick(); instr_valid = 1'b0;
        #1 chk("R5 int reads", read_grant, 4'b0001);
        tick(); exec_done = 4'b0001;
        tick(); exec_done = 4'b1000;
        #1 chk("R7 war hold", wb_grant, 4'b0000);
        tick(); exec_done = 4'b0000;
        #1 chk("R7 div writes, int held", wb_grant, 4'b1000);
        tick();
        #1 chk("R5 mul reads", read_grant, 4'b0100);
        chk("R7 still held at read", wb_grant, 4'b0000);
        tick();
        #1 chk("R7 released after read", wb_grant, 4'b0001);
        drain();
    endtask

    task automatic t_same_cycle();
        tick(); present(2'd0, 4'd1, 3'd3, 3'd0, 3'd0);
        #1 chk("R2 producer", issue_grant, 4'b0001);
        tick(); instr_valid = 1'b0;
        tick(); exec_done = 4'b0001;
        tick(); exec_done = 4'b0000; present(2'd1, 4'd2, 3'd4, 3'd3, 3'd3);
        #1 chk("R9 producer wb", wb_grant, 4'b0001);
        chk("R9 consumer issue", issue_grant, 4'b0100);
        tick(); instr_valid = 1'b0;
        #1 chk("R9 read next cycle", read_grant, 4'b0100);
        drain();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_struct();
        t_waw();
        t_raw();
        t_war();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule